// File: doc/BRIEF.md
# Whole-Cylinder Head Sequencer

This block moves the read/write head across every track of one cylinder during a transfer that covers the whole cylinder. It holds a head-selection counter, which a start command clears to head 0. At the end of each track it checks a set of format and timing qualifiers, and if they all hold it steps the counter once. A pending set-head request is then turned into a single load pulse toward the drive, timed by a bit strobe.

Each load pulse does three things:
- it clears the index-holdover flag;
- it opens a fresh gain-squelch window, so the drive's read amplifier settles before the next track;
- it confirms that address verification is needed only on the first track.

After the last head, the next step overflows the counter to one past the last head. The operation ends when three conditions meet: the overflow, bit time B4 or B5, and the end of the last check area.

The character timing generator supplies the digit and bit strobes. Only the strobes this block decodes are brought in: digit D5, bits B4, B5 and B7, and the bit strobe that gates the head load. The block does no data transfer and no address comparison.

Top module: `cyl_head_seq`

## Requirements
- R1: After reset `head_o` is 0 and `done_o`, `verify_o`, `load_o` and `squelch_o` are 0. One cycle of `start_i` clears the counter to 0, clears `done_o`, sets `verify_o` and queues a load of head 0.
- R2: The counter steps by exactly one per D5 digit window in which `cyl_mode_i`, `cmp_true_i`, `check_area_i` and `rec_hold_i` are high, `long_gap_i` is low and `b7_i` is low. If any one qualifier is missing, the counter holds. Qualifiers present only during B7 do not step it. Outside D5 nothing steps it.
- R3: After a start, and after each step that does not overflow, exactly one `load_o` pulse occurs. It coincides with `bload_i` and carries the new head number on `head_o`. Once the counter reaches `NUM_HEADS`, no load pulse occurs.
- R4: `index_i` sets `idx_hold_o` from the next cycle. A load pulse clears it, and a load pulse in the same cycle as `index_i` leaves it clear.
- R5: `squelch_o` is high for exactly `SQ_LEN` cycles, starting in the cycle after each load pulse.
- R6: `verify_o` stays high from a start until the first step of the counter, and stays low for the rest of the operation.
- R7: `done_o` rises only when `head_o` equals `NUM_HEADS`, `last_chk_end_i` is high and `b4_i` or `b5_i` is high. It stays high until the next `start_i`, and the same strobe at head counts below `NUM_HEADS` or at other bit times has no effect.
- R8: While `done_o` is high, qualified end-of-track windows leave `head_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a whole-cylinder operation |
| cyl_mode_i | input | 1 | Whole-cylinder mode active |
| cmp_true_i | input | 1 | Address compare true |
| check_area_i | input | 1 | Check area strobe |
| rec_hold_i | input | 1 | Record holdover strobe |
| long_gap_i | input | 1 | Long gap strobe |
| d5_i | input | 1 | Digit D5 strobe |
| b4_i | input | 1 | Bit B4 strobe |
| b5_i | input | 1 | Bit B5 strobe |
| b7_i | input | 1 | Bit B7 strobe |
| bload_i | input | 1 | Bit strobe that gates the head load |
| index_i | input | 1 | Index mark seen |
| last_chk_end_i | input | 1 | End of last check area |
| head_o | output | $clog2(NUM_HEADS+1) | Head counter |
| load_o | output | 1 | Head-load pulse to the drive |
| idx_hold_o | output | 1 | Index-holdover flag |
| squelch_o | output | 1 | Gain-squelch window |
| verify_o | output | 1 | Address verify enabled (first track only) |
| done_o | output | 1 | Operation finished |

## Verification
Two things can land in the same cycle: the head-load pulse that clears the index-holdover flag, and an index mark that sets the same flag. The bench provokes this by pulsing `index_i` in exactly the bit time of the load strobe, during the first real step. It judges the outcome at the ports: after that character the flag must read clear, while an earlier index mark that came after the load is seen to set it. The bench also drives the end-of-last-check-area strobe at a head count below the last and at a bit time outside B4 and B5, and expects `done_o` to stay low in both cases.

// File: rtl/cyl_head_pkg.sv
package cyl_head_pkg;
  typedef struct packed {
    logic cyl;
    logic cmp;
    logic chk;
    logic hold;
    logic lgap;
  } qual_t;

  function automatic logic qual_ok(qual_t q);
    return q.cyl & q.cmp & q.chk & q.hold & ~q.lgap;
  endfunction
endpackage

// File: rtl/chs_qualify.sv
module chs_qualify
  import cyl_head_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  qual_t q_i,
  input  logic  d5_i,
  input  logic  b7_i,
  output logic  adv_o
);
  logic eot, eot_q;

  assign eot = en_i & d5_i & ~b7_i & qual_ok(q_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) eot_q <= 1'b0;
    else         eot_q <= eot;

  // one step per D5 window: leading edge only
  assign adv_o = eot & ~eot_q;
endmodule

// File: rtl/chs_head_ctr.sv
module chs_head_ctr #(
  parameter int NUM_HEADS = 40,
  localparam int HW = $clog2(NUM_HEADS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic          bload_i,
  output logic [HW-1:0] head_o,
  output logic          load_o,
  output logic          ovf_o
);
  localparam logic [HW-1:0] LAST = HW'(NUM_HEADS - 1);
  localparam logic [HW-1:0] OVF  = HW'(NUM_HEADS);

  logic [HW-1:0] head_q;
  logic          req_q;

  assign load_o = req_q & bload_i;
  assign ovf_o  = (head_q == OVF);
  assign head_o = head_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      head_q <= '0;
      req_q  <= 1'b0;
    end else if (start_i) begin
      head_q <= '0;
      req_q  <= 1'b1;
    end else if (adv_i) begin
      head_q <= head_q + 1'b1;
      req_q  <= (head_q != LAST);
    end else if (load_o) begin
      req_q  <= 1'b0;
    end
endmodule

// File: rtl/chs_squelch.sv
module chs_squelch #(
  parameter int SQ_LEN = 16,
  localparam int CW = $clog2(SQ_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic sq_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= CW'(SQ_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

  assign sq_o = (cnt_q != '0);
endmodule

// File: rtl/cyl_head_seq.sv
module cyl_head_seq
  import cyl_head_pkg::*;
#(
  parameter int NUM_HEADS = 40,
  parameter int SQ_LEN    = 16,
  localparam int HW = $clog2(NUM_HEADS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cyl_mode_i,
  input  logic          cmp_true_i,
  input  logic          check_area_i,
  input  logic          rec_hold_i,
  input  logic          long_gap_i,
  input  logic          d5_i,
  input  logic          b4_i,
  input  logic          b5_i,
  input  logic          b7_i,
  input  logic          bload_i,
  input  logic          index_i,
  input  logic          last_chk_end_i,
  output logic [HW-1:0] head_o,
  output logic          load_o,
  output logic          idx_hold_o,
  output logic          squelch_o,
  output logic          verify_o,
  output logic          done_o
);
  logic  busy_q, done_q, verify_q, idx_q;
  logic  adv, ovf, load;
  qual_t q;

  assign q = '{cyl: cyl_mode_i, cmp: cmp_true_i, chk: check_area_i,
               hold: rec_hold_i, lgap: long_gap_i};

  chs_qualify u_qual (
    .clk_i, .rst_ni,
    .en_i  (busy_q & ~ovf & ~start_i),
    .q_i   (q),
    .d5_i, .b7_i,
    .adv_o (adv)
  );

  chs_head_ctr #(.NUM_HEADS(NUM_HEADS)) u_ctr (
    .clk_i, .rst_ni, .start_i,
    .adv_i   (adv),
    .bload_i,
    .head_o,
    .load_o  (load),
    .ovf_o   (ovf)
  );

  chs_squelch #(.SQ_LEN(SQ_LEN)) u_sq (
    .clk_i, .rst_ni,
    .trig_i (load),
    .sq_o   (squelch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      verify_q <= 1'b0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      verify_q <= 1'b1;
    end else begin
      if (adv) verify_q <= 1'b0;
      if (busy_q & ovf & (b4_i | b5_i) & last_chk_end_i) begin
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end
    end

  // load clear wins over a coincident index mark
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      idx_q <= 1'b0;
    else if (load)    idx_q <= 1'b0;
    else if (index_i) idx_q <= 1'b1;

  assign load_o     = load;
  assign idx_hold_o = idx_q;
  assign verify_o   = verify_q;
  assign done_o     = done_q;
endmodule

// File: rtl/cyl_head_seq_chk.sv
module cyl_head_seq_chk #(
  parameter int NUM_HEADS = 40,
  localparam int HW = $clog2(NUM_HEADS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          bload_i,
  input logic          last_chk_end_i,
  input logic [HW-1:0] head_o,
  input logic          load_o,
  input logic          idx_hold_o,
  input logic          squelch_o,
  input logic          verify_o,
  input logic          done_o
);
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (head_o == $past(head_o) || head_o == $past(head_o) + 1'b1));

  a_r3_load_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> bload_i);

  a_r3_no_load_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o == HW'(NUM_HEADS)) |-> !load_o);

  a_r4_idx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !idx_hold_o);

  a_r5_squelch_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> squelch_o);

  a_r6_verify_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!verify_o && !start_i) |=> !verify_o);

  a_r7_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r7_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(head_o) == HW'(NUM_HEADS) && $past(last_chk_end_i)));

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(head_o));
endmodule

bind cyl_head_seq cyl_head_seq_chk #(.NUM_HEADS(NUM_HEADS)) u_chk (
  .clk_i, .rst_ni, .start_i, .bload_i, .last_chk_end_i,
  .head_o, .load_o, .idx_hold_o, .squelch_o, .verify_o, .done_o
);

// File: tb/cyl_head_seq_test.sv
module cyl_head_seq_test;
  localparam int NH = 40;
  localparam int SQ = 16;
  localparam int HW = $clog2(NH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cyl = 0, cmp = 0, chk = 0, hold = 0, lgap = 0;
  logic d5 = 0, b4 = 0, b5 = 0, b7 = 0, bload = 0, idx = 0, lce = 0;
  logic [HW-1:0] head;
  logic load, idx_hold, squelch, verify, done;
  logic [4:0] qv;   // {cyl, cmp, chk, hold, lgap}

  int tests = 0, fails = 0, loads = 0, sq_cyc = 0;
  int last_load_head = -1;
  bit finished = 0;

  always #2 clk = ~clk;

  cyl_head_seq #(.NUM_HEADS(NH), .SQ_LEN(SQ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cyl_mode_i(cyl),
    .cmp_true_i(cmp), .check_area_i(chk), .rec_hold_i(hold),
    .long_gap_i(lgap), .d5_i(d5), .b4_i(b4), .b5_i(b5), .b7_i(b7),
    .bload_i(bload), .index_i(idx), .last_chk_end_i(lce),
    .head_o(head), .load_o(load), .idx_hold_o(idx_hold),
    .squelch_o(squelch), .verify_o(verify), .done_o(done)
  );

  always @(negedge clk) if (rst_n) begin
    if (load) begin loads++; last_load_head = int'(head); end
    if (squelch) sq_cyc++;
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one character: eight bit times, head load gated at B2
  task automatic char_run(bit dig5, bit only_b7, int lce_bit, int idx_bit);
    for (int b = 0; b < 8; b++) begin
      @(posedge clk); #1;
      d5 = dig5; b4 = (b == 4); b5 = (b == 5); b7 = (b == 7);
      bload = (b == 2); lce = (b == lce_bit); idx = (b == idx_bit);
      {cyl, cmp, chk, hold, lgap} = (!only_b7 || b == 7) ? qv : 5'b0;
    end
    @(posedge clk); #1;
    {d5, b4, b5, b7, bload, lce, idx} = '0;
    {cyl, cmp, chk, hold, lgap} = '0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    qv = 5'b11110;
    idle(3);
    // R1 reset state
    check("R1 head", int'(head), 0);
    check("R1 done", done, 0);
    check("R1 verify", verify, 0);
    check("R1 squelch", squelch, 0);
    rst_n = 1; idle(2);
    check("R1 load", loads, 0);

    pulse_start();
    check("R1 start head", int'(head), 0);
    check("R6 verify after start", verify, 1);

    // start load at B2, index mark later at B5 sets holdover
    char_run(0, 0, -1, 5);
    check("R3 start load count", loads, 1);
    check("R3 start load head", last_load_head, 0);
    check("R4 index sets holdover", idx_hold, 1);
    idle(20);
    check("R5 squelch length", sq_cyc, SQ);

    // R2 each qualifier missing in turn
    for (int k = 0; k < 5; k++) begin
      qv = 5'b11110 ^ (5'b1 << k);
      char_run(1, 0, -1, -1);
      check("R2 missing qualifier", int'(head), 0);
    end
    qv = 5'b11110;
    char_run(0, 0, -1, -1);
    check("R2 no D5", int'(head), 0);
    char_run(1, 1, -1, -1);
    check("R2 B7 only", int'(head), 0);
    check("R6 verify before step", verify, 1);

    // first step, index mark collides with load at B2
    char_run(1, 0, -1, 2);
    check("R2 first step", int'(head), 1);
    check("R4 clear wins", idx_hold, 0);
    check("R3 load count", loads, 2);
    check("R3 load head", last_load_head, 1);
    check("R6 verify dropped", verify, 0);
    idle(20);
    check("R5 squelch per load", sq_cyc, 2 * SQ);

    for (int t = 2; t < NH; t++) begin
      char_run(1, 0, (t == 20) ? 4 : -1, -1);
      check("R2 sweep head", int'(head), t);
      check("R3 sweep loads", loads, t + 1);
      check("R3 sweep load head", last_load_head, t);
      check("R7 no early done", done, 0);
      check("R6 verify stays low", verify, 0);
      idle(18);
    end
    check("R5 squelch total", sq_cyc, NH * SQ);

    // overflow step: no load
    char_run(1, 0, -1, -1);
    check("R3 overflow head", int'(head), NH);
    check("R3 no load on overflow", loads, NH);
    idle(18);
    check("R5 no squelch on overflow", sq_cyc, NH * SQ);
    check("R7 done waits", done, 0);

    char_run(0, 0, 6, -1);
    check("R7 wrong bit", done, 0);
    char_run(0, 0, 4, -1);
    check("R7 done on B4", done, 1);
    char_run(1, 0, -1, -1);
    check("R8 frozen head", int'(head), NH);
    check("R7 done held", done, 1);

    // restart, run through, end on B5
    pulse_start();
    check("R1 restart head", int'(head), 0);
    check("R1 restart done", done, 0);
    check("R6 restart verify", verify, 1);
    for (int t = 1; t <= NH; t++) char_run(1, 0, -1, -1);
    check("R2 second run head", int'(head), NH);
    char_run(0, 0, 5, -1);
    check("R7 done on B5", done, 1);

    summary();
  end
endmodule